// File: doc/BRIEF.md
# Equalizer Coefficient Store Controller

This block holds the coefficient words for a two-channel biquad equalizer and lets a host load and inspect them through two registers. A control register carries an equalizer-mute bit, a symmetry bit, a bank-select bit and a slot pointer. A data register is a window onto the coefficient word at the slot the pointer names, in the bank the select bit names. There is one bank for the left channel and one for the right. Each coefficient is a 16-bit fixed-point word, with bit 15 as the MSB and bit 0 as the LSB.

Coefficients can only be changed while the equalizer is muted. At reset the mute bit is set, which raises the bypass flag, so audio passes through unfiltered until the host has loaded the banks and clears the bit. A host write to the data register while the equalizer is running is discarded, and a one-cycle status pulse reports the rejected write. When the symmetry bit is set, every read of the right channel is served from the left bank, so the host loads one bank and both channels use it.

The filter datapath reads through its own port. It presents a channel bit, a slot and a valid strobe, and one cycle later it receives the word with a response valid. This port has no back-pressure: a request is accepted on every cycle its valid is high. The consumer must take each response in the cycle it appears, because the next accepted request overwrites it. Host reads follow the same one-cycle rule.

Top module: `eqc_store`

## Requirements
- R1: After reset the control register reads 0x8000 (mute 1, every other field 0), `eq_bypass` is 1, and every coefficient slot in both banks reads 0x0000 through the data register.
- R2: Control register layout: bit 15 is the equalizer mute, bit 13 is symmetry, bit 12 is bank select, and bits 5:0 are the slot pointer. Bits 14 and 11:6 are not stored and read as 0.
- R3: While mute is 1, a data-register write stores all 16 bits of write data, unchanged from MSB to LSB, at the pointed slot of the selected bank. A later data-register read of that slot returns the stored word.
- R4: While mute is 0, a data-register write leaves every coefficient unchanged. In the cycle after that write, `wr_ignored` is 1 for exactly one cycle. `wr_ignored` is 0 at all other times.
- R5: Bank select 0 addresses the left bank and 1 addresses the right bank. A write to one bank does not change the other.
- R6: While symmetry is 1, a host data read with bank select 1 and a filter fetch with `f_chan`=1 both return the left-bank word for the slot. Right-bank contents are kept and become visible again when symmetry is cleared.
- R7: A slot pointer at or above DEPTH (default 24): a write to it changes nothing, and a read of it returns 0x0000 on both the host port and the filter port.
- R8: `h_rvalid` is 1 in the cycle after `h_re` is 1 and 0 otherwise. `h_rdata` then holds the register (selected by `h_sel`: 0 control, 1 data) as it was when the read was issued.
- R9: `f_rvalid` is 1 in the cycle after `f_valid` is 1 and 0 otherwise. `f_coef` then holds the word for the requested channel and slot.
- R10: `eq_bypass` always equals the stored mute bit. It changes only in the cycle after a control-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host register select: 0 control, 1 data |
| h_we | input | 1 | Host write strobe |
| h_wdata | input | 16 | Host write data |
| h_re | input | 1 | Host read strobe |
| h_rdata | output | 16 | Host read data, valid with h_rvalid |
| h_rvalid | output | 1 | Host read data valid |
| wr_ignored | output | 1 | Pulse: data write rejected because the equalizer is not muted |
| f_valid | input | 1 | Filter fetch request valid |
| f_chan | input | 1 | Filter fetch channel: 0 left, 1 right |
| f_addr | input | 6 | Filter fetch slot |
| f_rvalid | output | 1 | Filter fetch response valid |
| f_coef | output | 16 | Fetched coefficient word |
| eq_bypass | output | 1 | Equalizer bypass flag (mute bit) |

## Verification
The bench fills every slot of both banks with patterns that differ per slot and per bank, and sets both the MSB and the LSB. It then reads all of them back through both ports. A crossed bank select, a dropped bit, or a reset value other than zero would show up as a mismatch on some slot. It sweeps every pointer value from DEPTH up to 63. A design that wraps these pointers would overwrite a real slot or return nonzero data. It toggles symmetry with different data in the two banks, so a right-bank alias that is missing, or that is also applied to the left channel, gives the wrong word. It also writes while unmuted and checks the rejection pulse, and it checks that the target slot keeps its old word.

// File: rtl/eqc_pkg.sv
package eqc_pkg;
  localparam int COEF_W  = 16;
  localparam int SLOT_AW = 6;

  // control register bit positions
  localparam int MUTE_BIT = 15;
  localparam int SYM_BIT  = 13;
  localparam int BANK_BIT = 12;

  typedef logic [COEF_W-1:0]  coef_t;
  typedef logic [SLOT_AW-1:0] slot_t;

  typedef struct packed {
    logic  mute;
    logic  sym;
    logic  bank;
    slot_t slot;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{mute: 1'b1, sym: 1'b0, bank: 1'b0, slot: '0};

  // right channel falls back to the left bank when symmetry is set
  function automatic logic eff_bank(input logic chan, input logic sym);
    return chan & ~sym;
  endfunction
endpackage

// File: rtl/eqc_ctrl.sv
module eqc_ctrl
  import eqc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  coef_t wdata,
  output ctl_t  ctl,
  output coef_t word
);
  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
    end else if (wr) begin
      ctl_q.mute <= wdata[MUTE_BIT];
      ctl_q.sym  <= wdata[SYM_BIT];
      ctl_q.bank <= wdata[BANK_BIT];
      ctl_q.slot <= wdata[SLOT_AW-1:0];
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[14], wdata[11:SLOT_AW]};

  always_comb begin
    word           = '0;
    word[MUTE_BIT] = ctl_q.mute;
    word[SYM_BIT]  = ctl_q.sym;
    word[BANK_BIT] = ctl_q.bank;
    word[SLOT_AW-1:0] = ctl_q.slot;
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/eqc_bank.sv
module eqc_bank
  import eqc_pkg::*;
#(
  parameter int DEPTH = 24
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  slot_t wr_slot,
  input  coef_t wr_data,
  input  slot_t ra_slot,
  output coef_t ra_data,
  input  slot_t rb_slot,
  output coef_t rb_data
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  coef_t mem [DEPTH];

  function automatic logic in_range(input slot_t s);
    return int'(s) < DEPTH;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && in_range(wr_slot)) begin
      mem[wr_slot[IW-1:0]] <= wr_data;
    end
  end

  assign ra_data = in_range(ra_slot) ? mem[ra_slot[IW-1:0]] : '0;
  assign rb_data = in_range(rb_slot) ? mem[rb_slot[IW-1:0]] : '0;
endmodule

// File: rtl/eqc_store.sv
module eqc_store
  import eqc_pkg::*;
#(
  parameter int DEPTH = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_sel,
  input  logic        h_we,
  input  logic [15:0] h_wdata,
  input  logic        h_re,
  output logic [15:0] h_rdata,
  output logic        h_rvalid,
  output logic        wr_ignored,
  input  logic        f_valid,
  input  logic        f_chan,
  input  logic [5:0]  f_addr,
  output logic        f_rvalid,
  output logic [15:0] f_coef,
  output logic        eq_bypass
);
  localparam int NBANK = 2;

  ctl_t  ctl_q;
  coef_t ctl_word;
  coef_t ra_data [NBANK];
  coef_t rb_data [NBANK];
  logic  data_wr;
  logic  host_bank, flt_bank;

  eqc_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (h_we & ~h_sel),
    .wdata (h_wdata),
    .ctl   (ctl_q),
    .word  (ctl_word)
  );

  assign data_wr = h_we & h_sel;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    eqc_bank #(.DEPTH(DEPTH)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (data_wr && ctl_q.mute && (ctl_q.bank == 1'(b))),
      .wr_slot (ctl_q.slot),
      .wr_data (h_wdata),
      .ra_slot (ctl_q.slot),
      .ra_data (ra_data[b]),
      .rb_slot (f_addr),
      .rb_data (rb_data[b])
    );
  end

  assign host_bank = eff_bank(ctl_q.bank, ctl_q.sym);
  assign flt_bank  = eff_bank(f_chan, ctl_q.sym);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rdata    <= '0;
      h_rvalid   <= 1'b0;
      wr_ignored <= 1'b0;
      f_rvalid   <= 1'b0;
      f_coef     <= '0;
    end else begin
      h_rvalid   <= h_re;
      wr_ignored <= data_wr & ~ctl_q.mute;
      f_rvalid   <= f_valid;
      if (h_re)    h_rdata <= h_sel ? ra_data[host_bank] : ctl_word;
      if (f_valid) f_coef  <= rb_data[flt_bank];
    end
  end

  assign eq_bypass = ctl_q.mute;
endmodule

// File: rtl/eqc_store_chk.sv
module eqc_store_chk #(
  parameter int DEPTH = 24
) (
  input logic        clk,
  input logic        rst_n,
  input logic        h_sel,
  input logic        h_we,
  input logic        h_re,
  input logic [15:0] h_rdata,
  input logic        h_rvalid,
  input logic        wr_ignored,
  input logic        f_valid,
  input logic [5:0]  f_addr,
  input logic        f_rvalid,
  input logic [15:0] f_coef,
  input logic        eq_bypass,
  input logic [5:0]  slot_ptr
);
  // R8
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_re |=> h_rvalid);
  // R8
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !h_re |=> !h_rvalid);
  // R4
  ignore_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_sel && !eq_bypass) |=> wr_ignored);
  // R4
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_we && h_sel && !eq_bypass) |=> !wr_ignored);
  // R9
  fetch_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_valid |=> f_rvalid);
  // R9
  fetch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !f_valid |=> !f_rvalid);
  // R10
  bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_we && !h_sel) |=> $stable(eq_bypass));
  // R2
  ctl_mute_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_re && !h_sel && !h_we) |=> (h_rdata[15] == eq_bypass && h_rdata[14] == 1'b0));
  // R7
  range_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_re && h_sel && !h_we && int'(slot_ptr) >= DEPTH) |=> h_rdata == 16'h0000);
  // R7
  range_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && int'(f_addr) >= DEPTH) |=> f_coef == 16'h0000);
endmodule

bind eqc_store eqc_store_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .h_sel      (h_sel),
  .h_we       (h_we),
  .h_re       (h_re),
  .h_rdata    (h_rdata),
  .h_rvalid   (h_rvalid),
  .wr_ignored (wr_ignored),
  .f_valid    (f_valid),
  .f_addr     (f_addr),
  .f_rvalid   (f_rvalid),
  .f_coef     (f_coef),
  .eq_bypass  (eq_bypass),
  .slot_ptr   (ctl_q.slot)
);

// File: tb/sim_eqc_store.sv
`timescale 1ns/1ps
module sim_eqc_store;
  localparam int DEPTH = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_sel = 1'b0, h_we = 1'b0, h_re = 1'b0;
  logic [15:0] h_wdata = '0;
  logic [15:0] h_rdata;
  logic        h_rvalid, wr_ignored;
  logic        f_valid = 1'b0, f_chan = 1'b0;
  logic [5:0]  f_addr = '0;
  logic        f_rvalid, eq_bypass;
  logic [15:0] f_coef;

  int errors = 0;
  int checks = 0;
  logic ign;

  always #2 clk = ~clk;

  eqc_store #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_we(h_we), .h_wdata(h_wdata),
    .h_re(h_re), .h_rdata(h_rdata), .h_rvalid(h_rvalid), .wr_ignored(wr_ignored),
    .f_valid(f_valid), .f_chan(f_chan), .f_addr(f_addr), .f_rvalid(f_rvalid),
    .f_coef(f_coef), .eq_bypass(eq_bypass)
  );

  function automatic logic [15:0] lpat(input int i);
    return 16'h8001 ^ 16'(i * 16'h0513);
  endfunction
  function automatic logic [15:0] rpat(input int i);
    return 16'h4001 ^ 16'(i * 16'h0321 + 16'h0700);
  endfunction
  function automatic logic [15:0] cw(input logic m, input logic s, input logic b, input int a);
    return {m, 1'b0, s, b, 6'b0, 6'(a)};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    h_sel = sel; h_we = 1'b1; h_wdata = d;
    @(negedge clk);
    h_we = 1'b0;
    ign = wr_ignored;
  endtask

  task automatic hrd(input logic sel, output logic [15:0] d, output logic v);
    @(negedge clk);
    h_sel = sel; h_re = 1'b1;
    @(negedge clk);
    h_re = 1'b0;
    d = h_rdata; v = h_rvalid;
  endtask

  task automatic frd(input logic ch, input int a, output logic [15:0] d, output logic v);
    @(negedge clk);
    f_valid = 1'b1; f_chan = ch; f_addr = 6'(a);
    @(negedge clk);
    f_valid = 1'b0;
    d = f_coef; v = f_rvalid;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    hrd(1'b0, d, v);
    chk("R1 ctrl reset", d, 16'h8000);
    chk("R8 rvalid", {15'b0, v}, 16'h0001);
    chk("R10 bypass reset", {15'b0, eq_bypass}, 16'h0001);
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++) begin
        hwr(1'b0, cw(1, 0, b[0], i));
        hrd(1'b1, d, v);
        chk("R1 slot zero", d, 16'h0000);
      end

    // R2: layout, unused bits read 0
    hwr(1'b0, 16'h7FFF);
    hrd(1'b0, d, v);
    chk("R2 ctrl layout", d, 16'h303F);
    chk("R10 bypass clear", {15'b0, eq_bypass}, 16'h0000);
    hwr(1'b0, 16'hCFC5);
    hrd(1'b0, d, v);
    chk("R2 ctrl layout", d, 16'h8005);

    // R3 R5: fill both banks
    for (int i = 0; i < DEPTH; i++) begin
      hwr(1'b0, cw(1, 0, 0, i)); hwr(1'b1, lpat(i));
      chk("R4 no pulse when muted", {15'b0, ign}, 16'h0000);
      hwr(1'b0, cw(1, 0, 1, i)); hwr(1'b1, rpat(i));
    end
    // R7: out-of-range writes to both banks
    for (int i = DEPTH; i < 64; i++) begin
      hwr(1'b0, cw(1, 0, i[0], i)); hwr(1'b1, 16'hFFFF);
      hrd(1'b1, d, v);
      chk("R7 host out of range", d, 16'h0000);
      frd(i[0], i, d, v);
      chk("R7 fetch out of range", d, 16'h0000);
    end
    for (int i = 0; i < DEPTH; i++) begin
      hwr(1'b0, cw(1, 0, 0, i));
      hrd(1'b1, d, v);
      chk("R3 left readback", d, lpat(i));
      hwr(1'b0, cw(1, 0, 1, i));
      hrd(1'b1, d, v);
      chk("R5 right readback", d, rpat(i));
      frd(1'b0, i, d, v);
      chk("R9 fetch left", d, lpat(i));
      chk("R9 f_rvalid", {15'b0, v}, 16'h0001);
      frd(1'b1, i, d, v);
      chk("R9 fetch right", d, rpat(i));
    end

    // R6: symmetry aliases the right channel
    for (int i = 0; i < DEPTH; i++) begin
      hwr(1'b0, cw(1, 1, 1, i));
      hrd(1'b1, d, v);
      chk("R6 host sym right", d, lpat(i));
      frd(1'b1, i, d, v);
      chk("R6 fetch sym right", d, lpat(i));
      frd(1'b0, i, d, v);
      chk("R6 fetch sym left", d, lpat(i));
    end
    hwr(1'b0, cw(1, 0, 1, 7));
    hrd(1'b1, d, v);
    chk("R6 right kept", d, rpat(7));

    // R4: unmuted write rejected
    hwr(1'b0, cw(0, 0, 0, 3));
    chk("R10 bypass follows mute", {15'b0, eq_bypass}, 16'h0000);
    hwr(1'b1, 16'hDEAD);
    chk("R4 ignore pulse", {15'b0, ign}, 16'h0001);
    @(negedge clk);
    chk("R4 pulse one cycle", {15'b0, wr_ignored}, 16'h0000);
    hrd(1'b1, d, v);
    chk("R4 slot unchanged", d, lpat(3));
    frd(1'b0, 3, d, v);
    chk("R4 fetch unchanged", d, lpat(3));
    hwr(1'b0, cw(1, 0, 0, 3));
    hwr(1'b1, 16'h8001);
    chk("R4 no pulse muted", {15'b0, ign}, 16'h0000);
    hrd(1'b1, d, v);
    chk("R3 msb lsb", d, 16'h8001);

    // R8: no read, no valid
    @(negedge clk);
    chk("R8 rvalid idle", {15'b0, h_rvalid}, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule